// File: doc/BRIEF.md
# USB Endpoint Transaction Status Tracker

This block holds the per-endpoint control, expected-count, status and count-result registers of a USB device controller. A protocol engine upstream reports each finished transaction as a one-cycle event. The event carries the endpoint number, the kind of packet, whether its CRC checked good, the received byte count, the data toggle and whether the transaction was ACKed. From each event the block rewrites that endpoint's status word. When the received length of an OUT data packet disagrees with the programmed expected count, the block also stores how many bytes it was off by.

The block also decides whether an event is taken at all. Setup packets need only the endpoint enable bit. Data packets also need the arm bit and a matching direction. When a setup packet is taken, the block reports the buffer address where its eight bytes belong. A bit-time-driven wait timer covers a missing handshake after IN data, or a missing OUT data stage, and marks the endpoint as timed out. Firmware reaches all registers through a simple word read/write port.

Top module: `ep_status_tracker`

## Requirements
- R1: A SETUP event (kind code 1) is taken whenever the endpoint's enable bit (control bit 0) is 1, whatever the arm bit (control bit 1) and direction bit (control bit 2) hold. In that cycle `setup_accept` is 1, and after the edge status bit 4 of that endpoint is 1.
- R2: While `setup_accept` is 1, `setup_addr` shows 0x0300 for device instance 0 and 0x0308 for device instance 1. Otherwise it shows 0.
- R3: Status bit 3 takes the toggle of a taken OUT or SETUP packet (1 = DATA1, 0 = DATA0). An IN completion or an unexpected-kind event keeps the old value of bit 3. A toggle that repeats or skips never stops a packet from being taken.
- R4: Status bit 1 (error) is set when the CRC is reported bad or the event kind is unexpected (code 3). A length mismatch with a good CRC leaves bit 1 clear.
- R5: For a taken OUT data event (code 0) whose length differs from the endpoint's expected count, status bit 6 (length exception) is set. Bit 11 is also set when more bytes arrived than expected, or bit 10 when fewer arrived. SETUP and IN events never set bits 6, 10 or 11.
- R6: On a length exception, the count result takes expected minus received for an underflow, or received minus expected for an overflow. When the lengths match, or the event is not OUT data, the count result is left unchanged.
- R7: Status bit 0 of a taken event equals the event's ACK input.
- R8: After a `wait_start` pulse, TO_BITS pulses of `bit_tick` with no `wait_stop` write the waited endpoint's status to bit 2 set, bit 3 kept and every other bit 0. After TO_BITS-1 pulses the status is unchanged, and a `wait_stop` cancels the wait.
- R9: Each taken event rewrites the whole status word, so no flag from an earlier transaction stays set.
- R10: OUT data needs enable=1, arm=1 and direction=0. An IN completion (code 2) needs enable=1, arm=1 and direction=1. An unexpected-kind event needs enable=1. Any other event is ignored: status and count result stay unchanged and `data_accept` is 0. `data_accept` is 1 only for taken OUT and IN events.
- R11: The register address is {endpoint, select}, with select 0 = control, 1 = expected count, 2 = status and 3 = count result. Writes overwrite the register. Reads return it combinationally. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Transaction-completion event strobe |
| evt_ep | input | EPW | Endpoint of the event |
| evt_kind | input | 2 | 0 OUT data, 1 SETUP, 2 IN completion, 3 unexpected |
| evt_crc_ok | input | 1 | CRC of the packet checked good |
| evt_len | input | DW | Received byte count |
| evt_toggle | input | 1 | Data toggle, 1 = DATA1 |
| evt_ack | input | 1 | Transaction ended with ACK |
| wait_start | input | 1 | Start the handshake/data-stage wait |
| wait_ep | input | EPW | Endpoint that is waiting |
| wait_stop | input | 1 | Awaited packet arrived |
| bit_tick | input | 1 | One pulse per bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | EPW+2 | {endpoint, select} |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data |
| setup_accept | output | 1 | Setup packet taken this cycle |
| setup_addr | output | 16 | Buffer address for the setup data |
| data_accept | output | 1 | OUT or IN event taken this cycle |

## Verification
The assertions assume that firmware does not write a register in the same cycle that the hardware updates it, and that `evt_ep` and `wait_ep` are stable, known values whenever their strobes are high. The bench drives every strobe at the falling edge for exactly one cycle. It keeps register writes, events and timer pulses in separate cycles, and the endpoints it names always exist. The length checks assume that the expected count does not change between an event and the edge that records it, and the stimulus programs every count before any traffic.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;

    typedef enum logic [1:0] {
        EV_OUT   = 2'd0,
        EV_SETUP = 2'd1,
        EV_IN    = 2'd2,
        EV_BAD   = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        RS_CTRL  = 2'd0,
        RS_COUNT = 2'd1,
        RS_STAT  = 2'd2,
        RS_RES   = 2'd3
    } reg_sel_e;

    localparam int ST_ACK   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_TMO   = 2;
    localparam int ST_SEQ   = 3;
    localparam int ST_SETUP = 4;
    localparam int ST_LENX  = 6;
    localparam int ST_UNF   = 10;
    localparam int ST_OVF   = 11;

    localparam int CTL_EN    = 0;
    localparam int CTL_ARM   = 1;
    localparam int CTL_DIRIN = 2;
    localparam int CTL_W     = 3;

endpackage

// File: rtl/ep_len_cmp.sv
module ep_len_cmp #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] exp_len,
    input  logic [DW-1:0] rx_len,
    output logic          len_exc,
    output logic          len_ovf,
    output logic          len_unf,
    output logic [DW-1:0] len_diff
);
    always_comb begin
        len_ovf  = rx_len > exp_len;
        len_unf  = rx_len < exp_len;
        len_exc  = len_ovf || len_unf;
        len_diff = len_ovf ? (rx_len - exp_len) : (exp_len - rx_len);
    end
endmodule

// File: rtl/ep_wait_timer.sv
module ep_wait_timer #(
    parameter int EPW     = 2,
    parameter int TO_BITS = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [EPW-1:0] start_ep,
    input  logic           stop,
    input  logic           tick,
    output logic           expire,
    output logic [EPW-1:0] expire_ep
);
    localparam int TW = $clog2(TO_BITS + 1);

    typedef struct packed {
        logic           act;
        logic [EPW-1:0] ep;
        logic [TW-1:0]  cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        expire    = t_q.act && tick && !stop && (t_q.cnt == TW'(TO_BITS - 1));
        expire_ep = t_q.ep;
        if (t_q.act && tick) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
        if (expire || stop) begin
            t_d.act = 1'b0;
        end
        if (start) begin
            t_d.act = 1'b1;
            t_d.ep  = start_ep;
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R8
    tmo_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.act |-> (t_q.cnt < TW'(TO_BITS)));

endmodule

// File: rtl/ep_status_tracker.sv
module ep_status_tracker
    import ep_stat_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int DEV_INST = 0,
    parameter int TO_BITS  = 18,
    parameter int DW       = 16,
    parameter int EPW      = $clog2(NUM_EP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_valid,
    input  logic [EPW-1:0] evt_ep,
    input  logic [1:0]     evt_kind,
    input  logic           evt_crc_ok,
    input  logic [DW-1:0]  evt_len,
    input  logic           evt_toggle,
    input  logic           evt_ack,
    input  logic           wait_start,
    input  logic [EPW-1:0] wait_ep,
    input  logic           wait_stop,
    input  logic           bit_tick,
    input  logic           reg_wr,
    input  logic [EPW+1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           setup_accept,
    output logic [15:0]    setup_addr,
    output logic           data_accept
);
    localparam logic [15:0] SETUP_BASE = 16'h0300 + 16'(DEV_INST * 8);

    typedef struct packed {
        logic [NUM_EP-1:0][CTL_W-1:0] ctl;
        logic [NUM_EP-1:0][DW-1:0]    cnt;
        logic [NUM_EP-1:0][DW-1:0]    st;
        logic [NUM_EP-1:0][DW-1:0]    res;
    } regs_t;

    regs_t r_d, r_q;

    ev_kind_e       kind;
    reg_sel_e       sel;
    logic [EPW-1:0] rep;
    logic [CTL_W-1:0] ev_ctl;
    logic           bad_take;
    logic           any_take;
    logic           lx, lovf, lunf;
    logic [DW-1:0]  ldiff;
    logic           expire;
    logic [EPW-1:0] expire_ep;
    logic [DW-1:0]  st_new;
    logic [DW-1:0]  tmo_new;

    assign kind = ev_kind_e'(evt_kind);
    assign sel  = reg_sel_e'(reg_addr[1:0]);
    assign rep  = reg_addr[EPW+1:2];

    ep_len_cmp #(.DW(DW)) u_len (
        .exp_len  (r_q.cnt[evt_ep]),
        .rx_len   (evt_len),
        .len_exc  (lx),
        .len_ovf  (lovf),
        .len_unf  (lunf),
        .len_diff (ldiff)
    );

    ep_wait_timer #(.EPW(EPW), .TO_BITS(TO_BITS)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wait_start),
        .start_ep  (wait_ep),
        .stop      (wait_stop),
        .tick      (bit_tick),
        .expire    (expire),
        .expire_ep (expire_ep)
    );

    always_comb begin
        r_d    = r_q;
        ev_ctl = r_q.ctl[evt_ep];
        st_new = '0;
        tmo_new = '0;

        setup_accept = evt_valid && (kind == EV_SETUP) && ev_ctl[CTL_EN];
        data_accept  = evt_valid && ev_ctl[CTL_EN] && ev_ctl[CTL_ARM] &&
                       (((kind == EV_OUT) && !ev_ctl[CTL_DIRIN]) ||
                        ((kind == EV_IN)  &&  ev_ctl[CTL_DIRIN]));
        bad_take     = evt_valid && (kind == EV_BAD) && ev_ctl[CTL_EN];
        any_take     = setup_accept || data_accept || bad_take;
        setup_addr   = setup_accept ? SETUP_BASE : 16'h0000;

        // firmware write, lowest priority
        if (reg_wr) begin
            case (sel)
                RS_CTRL:  r_d.ctl[rep] = reg_wdata[CTL_W-1:0];
                RS_COUNT: r_d.cnt[rep] = reg_wdata;
                RS_STAT:  r_d.st[rep]  = reg_wdata;
                default:  r_d.res[rep] = reg_wdata;
            endcase
        end

        // transaction completion
        if (any_take) begin
            st_new[ST_ACK]   = evt_ack;
            st_new[ST_ERR]   = !evt_crc_ok || (kind == EV_BAD);
            st_new[ST_SEQ]   = ((kind == EV_OUT) || (kind == EV_SETUP)) ?
                               evt_toggle : r_q.st[evt_ep][ST_SEQ];
            st_new[ST_SETUP] = (kind == EV_SETUP);
            if ((kind == EV_OUT) && lx) begin
                st_new[ST_LENX] = 1'b1;
                st_new[ST_OVF]  = lovf;
                st_new[ST_UNF]  = lunf;
                r_d.res[evt_ep] = ldiff;
            end
            r_d.st[evt_ep] = st_new;
        end

        // wait window ran out, highest priority
        if (expire) begin
            tmo_new[ST_TMO] = 1'b1;
            tmo_new[ST_SEQ] = r_d.st[expire_ep][ST_SEQ];
            r_d.st[expire_ep] = tmo_new;
        end

        case (sel)
            RS_CTRL:  reg_rdata = {{(DW-CTL_W){1'b0}}, r_q.ctl[rep]};
            RS_COUNT: reg_rdata = r_q.cnt[rep];
            RS_STAT:  reg_rdata = r_q.st[rep];
            default:  reg_rdata = r_q.res[rep];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R1
    setup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_accept && !expire) |=> r_q.st[$past(evt_ep)][ST_SETUP]);

    // R4
    len_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_accept && (kind == EV_OUT) && evt_crc_ok && !expire)
        |=> !r_q.st[$past(evt_ep)][ST_ERR]);

    // R5
    ovf_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_accept && (kind == EV_OUT) && (evt_len > r_q.cnt[evt_ep]) && !expire)
        |=> (r_q.st[$past(evt_ep)][ST_OVF] && !r_q.st[$past(evt_ep)][ST_UNF]));

    // R8
    tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.st[$past(expire_ep)][ST_TMO]);

    // R10
    ignored_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !any_take && !expire && !reg_wr)
        |=> ($stable(r_q.st) && $stable(r_q.res)));

endmodule

// File: tb/sim_ep_status_tracker.sv
module sim_ep_status_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_ep = '0;
    logic [1:0]  evt_kind = '0;
    logic        evt_crc_ok = 1'b0;
    logic [15:0] evt_len = '0;
    logic        evt_toggle = 1'b0;
    logic        evt_ack = 1'b0;
    logic        wait_start = 1'b0;
    logic [1:0]  wait_ep = '0;
    logic        wait_stop = 1'b0;
    logic        bit_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        setup_accept;
    logic [15:0] setup_addr;
    logic        data_accept;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ep_status_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_ep(evt_ep), .evt_kind(evt_kind),
        .evt_crc_ok(evt_crc_ok), .evt_len(evt_len), .evt_toggle(evt_toggle),
        .evt_ack(evt_ack), .wait_start(wait_start), .wait_ep(wait_ep),
        .wait_stop(wait_stop), .bit_tick(bit_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .setup_accept(setup_accept), .setup_addr(setup_addr),
        .data_accept(data_accept)
    );

    typedef struct packed {
        logic [1:0]  ep;
        logic [1:0]  kind;
        logic        crc;
        logic [15:0] len;
        logic        tog;
        logic        ack;
        logic        x_sa;
        logic        x_da;
        logic [15:0] x_st;
        logic [15:0] x_res;
    } vec_t;

    localparam int NV = 16;
    // ep0 OUT armed count 64, ep1 IN armed, ep2 enabled only, ep3 disabled
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 1'b1, 16'd64, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0009, 16'd0},
        '{2'd0, 2'd0, 1'b1, 16'd60, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0441, 16'd4},
        '{2'd0, 2'd0, 1'b1, 16'd70, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0849, 16'd6},
        '{2'd0, 2'd0, 1'b0, 16'd64, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0002, 16'd6},
        '{2'd0, 2'd0, 1'b0, 16'd10, 1'b1, 1'b0, 1'b0, 1'b1, 16'h044A, 16'd54},
        '{2'd2, 2'd1, 1'b1, 16'd8,  1'b0, 1'b1, 1'b1, 1'b0, 16'h0011, 16'd0},
        '{2'd1, 2'd1, 1'b1, 16'd8,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0019, 16'd0},
        '{2'd1, 2'd2, 1'b1, 16'd0,  1'b0, 1'b1, 1'b0, 1'b1, 16'h0009, 16'd0},
        '{2'd1, 2'd2, 1'b1, 16'd0,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0008, 16'd0},
        '{2'd0, 2'd3, 1'b1, 16'd0,  1'b0, 1'b0, 1'b0, 1'b0, 16'h000A, 16'd54},
        '{2'd2, 2'd0, 1'b1, 16'd64, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0011, 16'd0},
        '{2'd3, 2'd1, 1'b1, 16'd8,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'd0},
        '{2'd1, 2'd0, 1'b1, 16'd5,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0008, 16'd0},
        '{2'd0, 2'd2, 1'b1, 16'd3,  1'b1, 1'b1, 1'b0, 1'b0, 16'h000A, 16'd54},
        '{2'd3, 2'd3, 1'b1, 16'd0,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'd0},
        '{2'd1, 2'd2, 1'b0, 16'd0,  1'b0, 1'b0, 1'b0, 1'b1, 16'h000A, 16'd0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ep, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {ep, sel}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ep, input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        reg_addr = {ep, sel};
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, 2'd2, v); chk("R11 reset status", v, 16'h0000);
        rd(2'd0, 2'd3, v); chk("R11 reset result", v, 16'h0000);
        rd(2'd1, 2'd0, v); chk("R11 reset ctrl", v, 16'h0000);

        wr(2'd0, 2'd0, 16'h0003);
        wr(2'd0, 2'd1, 16'd64);
        wr(2'd1, 2'd0, 16'h0007);
        wr(2'd2, 2'd0, 16'h0001);
        rd(2'd0, 2'd1, v); chk("R11 count readback", v, 16'd64);
        rd(2'd1, 2'd0, v); chk("R11 ctrl readback", v, 16'h0007);

        // table walk: R1 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_valid = 1'b1; evt_ep = VEC[i].ep; evt_kind = VEC[i].kind;
            evt_crc_ok = VEC[i].crc; evt_len = VEC[i].len;
            evt_toggle = VEC[i].tog; evt_ack = VEC[i].ack;
            #1;
            chk($sformatf("R1 setup_accept v%0d", i), 16'(setup_accept), 16'(VEC[i].x_sa));
            chk($sformatf("R10 data_accept v%0d", i), 16'(data_accept), 16'(VEC[i].x_da));
            if (VEC[i].x_sa) chk($sformatf("R2 setup_addr v%0d", i), setup_addr, 16'h0300);
            @(negedge clk);
            evt_valid = 1'b0;
            rd(VEC[i].ep, 2'd2, v);
            chk($sformatf("R9 status v%0d", i), v, VEC[i].x_st);
            rd(VEC[i].ep, 2'd3, v);
            chk($sformatf("R6 result v%0d", i), v, VEC[i].x_res);
        end

        // R2 address idle when nothing taken
        chk("R2 setup_addr idle", setup_addr, 16'h0000);

        // R8 timeout on ep1 (status 0x000A, seq=1)
        @(negedge clk); wait_start = 1'b1; wait_ep = 2'd1;
        @(negedge clk); wait_start = 1'b0;
        for (int k = 0; k < 17; k++) tick();
        rd(2'd1, 2'd2, v); chk("R8 before window end", v, 16'h000A);
        tick();
        rd(2'd1, 2'd2, v); chk("R8 timeout set", v, 16'h000C);

        // R8 cancel on ep0
        @(negedge clk); wait_start = 1'b1; wait_ep = 2'd0;
        @(negedge clk); wait_start = 1'b0;
        for (int k = 0; k < 5; k++) tick();
        @(negedge clk); wait_stop = 1'b1;
        @(negedge clk); wait_stop = 1'b0;
        for (int k = 0; k < 30; k++) tick();
        rd(2'd0, 2'd2, v); chk("R8 cancelled wait", v, 16'h000A);

        // R11 firmware overwrite and clear
        wr(2'd2, 2'd2, 16'h0000);
        rd(2'd2, 2'd2, v); chk("R11 status clear", v, 16'h0000);
        wr(2'd3, 2'd3, 16'h1234);
        rd(2'd3, 2'd3, v); chk("R11 result write", v, 16'h1234);

        // R3 toggle repeat still taken, R7 ack
        @(negedge clk);
        evt_valid = 1'b1; evt_ep = 2'd0; evt_kind = 2'd0; evt_crc_ok = 1'b1;
        evt_len = 16'd64; evt_toggle = 1'b0; evt_ack = 1'b1;
        #1 chk("R3 repeat toggle taken", 16'(data_accept), 16'd1);
        @(negedge clk); evt_valid = 1'b0;
        rd(2'd0, 2'd2, v); chk("R7 ack with DATA0", v, 16'h0001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule